// File: doc/BRIEF.md
# BCD calendar counter with carry flag

This block keeps wall-clock time as packed BCD registers: seconds, minutes, hours, weekday, day of month, month and year. The year has a century byte that can be left out at build time. A binary sub-second counter sits below the seconds and advances once per enable tick, normally 128 per second. When it wraps, the calendar moves forward one second and the carry flag is set. Months have their true lengths, and February is handled for leap years. Software reaches every register through a byte-wide bus with read, write, a 4-bit address and data. Reads are combinational.

Software sets the time by clearing the start bit, which freezes the counters and opens them to writes. It then loads the fields, pulses the prescaler reset and sets start again. To read the time it clears the carry flag, reads the fields and checks the flag afterwards. A flag that is set again means a second elapsed during the read, and the read must be repeated. A 30-second adjust request snaps the time to the nearest whole minute.

The sequencing is one state machine with four states:
- STOP (not counting) goes to ADJ on an adjust request, or to RUN once start and enable are set with prescaler reset clear.
- RUN advances the sub-second counter on each tick. It goes to ADJ on an adjust request, to STOP when counting is no longer allowed, and to CARRY when the sub-second counter wraps.
- CARRY advances the calendar by one second, sets the carry flag, and returns to RUN, or to STOP if counting has been disabled.
- ADJ performs the adjustment, clears the request, and returns to RUN or STOP.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the calendar reads 2000-01-01 (century byte 0x20), weekday 0, time 00:00:00. The sub-second counter, both control registers and `carry_irq` read 0.
- R2: When the sub-second counter has advanced TICKS_PER_SEC times, the calendar gains one second. Seconds and minutes roll from 0x59 to 0x00, carrying upward, and hours roll from 0x23 to 0x00. The sub-second count is readable at offset 0.
- R3: The day rolls from the month's last day (0x28, 0x29, 0x30 or 0x31) to 0x01 and the month advances. Leap years are the years whose two low digits are divisible by 4. Month 0x12 rolls to 0x01 and the year increments, and year 0x99 rolls to 0x00 with a carry into the century byte.
- R4: The weekday advances whenever the day advances, wrapping from 6 to 0.
- R5: The counters do not change while start (control 2 bit 0) or enable (control 2 bit 3) is 0, whatever the tick input does.
  - Counter fields are written at offsets 1–8: seconds, minutes, hours, weekday, day, month, year, century.
  - Writes to these fields take effect only while start is 0 and are ignored while start is 1.
- R6: While prescaler reset (control 2 bit 1) is 1, the sub-second counter is held at 0.
- R7: The carry flag (control 1 bit 7, offset 14) is set on every sub-second wrap.
  - It stays set until software writes that bit as 0. Writing 1 leaves it unchanged.
  - When a wrap and a clearing write fall in the same cycle, the wrap wins.
- R8: `carry_irq` is high exactly when the carry flag and the carry interrupt enable (control 1 bit 4) are both 1.
- R9: Writing 1 to control 2 bit 2 (offset 15) requests an adjustment. The request bit reads back 0 once the adjustment is done.
  - The adjustment clears the sub-second counter.
  - Seconds below 0x30 are cleared.
  - Seconds of 0x30 or more clear and advance the minute, carrying through the whole calendar.
- R10: Offsets other than 0–8, 14 and 15 read 0, and unused control bits read 0. `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second enable pulse, one clock wide |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench builds the block with TICKS_PER_SEC = 4 and the four-digit year enabled. With only four ticks per second, every second is walked tick by tick. That keeps cascades through minute, hour, month, year and century rollover within a few dozen cycles each. The century byte also makes the 2099-to-2100 carry observable at the bus. A calendar table covers leap and non-leap Februaries, 30- and 31-day months, BCD digit carries and weekday wrap. Directed tests cover the hold, write-protect, prescaler reset, flag and adjust behaviour.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr_hi;
        logic [7:0] yr_lo;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] wday;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef enum logic [1:0] {
        ST_STOP,
        ST_RUN,
        ST_CARRY,
        ST_ADJ
    } rtc_state_e;

    localparam logic [3:0] OFS_SUB  = 4'd0;
    localparam logic [3:0] OFS_SEC  = 4'd1;
    localparam logic [3:0] OFS_MIN  = 4'd2;
    localparam logic [3:0] OFS_HR   = 4'd3;
    localparam logic [3:0] OFS_WDAY = 4'd4;
    localparam logic [3:0] OFS_DAY  = 4'd5;
    localparam logic [3:0] OFS_MON  = 4'd6;
    localparam logic [3:0] OFS_YRLO = 4'd7;
    localparam logic [3:0] OFS_YRHI = 4'd8;
    localparam logic [3:0] OFS_CTL1 = 4'd14;
    localparam logic [3:0] OFS_CTL2 = 4'd15;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two BCD digits divisible by 4: even tens with 0/4/8, odd tens with 2/6
    function automatic logic is_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int TICKS_PER_SEC = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic [7:0] cnt_byte,
    output logic at_max
);
    localparam int SUB_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [SUB_W-1:0] CNT_MAX = SUB_W'(TICKS_PER_SEC - 1);

    logic [SUB_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (adv)       cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end

    assign at_max   = (cnt_q == CNT_MAX);
    assign cnt_byte = 8'(cnt_q);
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_pkg::*;
#(
    parameter bit FOUR_DIGIT_YEAR = 1'b1
) (
    input  cal_t cur,
    input  logic from_min,
    output cal_t nxt
);
    logic sec_w, min_w, hr_w, day_w, mon_w, yr_w;

    always_comb begin
        nxt   = cur;
        sec_w = from_min || (cur.sec == 8'h59);
        min_w = sec_w && (cur.min == 8'h59);
        hr_w  = min_w && (cur.hr == 8'h23);
        day_w = hr_w && (cur.day >= month_last(cur.mon, cur.yr_lo));
        mon_w = day_w && (cur.mon >= 8'h12);
        yr_w  = mon_w && (cur.yr_lo == 8'h99);

        nxt.sec = sec_w ? 8'h00 : bcd_inc(cur.sec);
        if (sec_w) nxt.min = min_w ? 8'h00 : bcd_inc(cur.min);
        if (min_w) nxt.hr  = hr_w  ? 8'h00 : bcd_inc(cur.hr);
        if (hr_w) begin
            nxt.day  = day_w ? 8'h01 : bcd_inc(cur.day);
            nxt.wday = (cur.wday >= 8'h06) ? 8'h00 : cur.wday + 8'h01;
        end
        if (day_w) nxt.mon   = mon_w ? 8'h01 : bcd_inc(cur.mon);
        if (mon_w) nxt.yr_lo = yr_w  ? 8'h00 : bcd_inc(cur.yr_lo);
        if (FOUR_DIGIT_YEAR && yr_w)
            nxt.yr_hi = (cur.yr_hi == 8'h99) ? 8'h00 : bcd_inc(cur.yr_hi);
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC   = 128,
    parameter bit FOUR_DIGIT_YEAR = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       carry_irq
);
    localparam logic [7:0] RST_CENTURY = FOUR_DIGIT_YEAR ? 8'h20 : 8'h00;

    rtc_state_e state_q, state_d;
    cal_t       cal_q, step_nxt;
    logic       cf_q, cie_q, en_q, adj_q, prst_q, start_q;
    logic       run, sub_at_max, wrap;
    logic [7:0] sub_byte;
    logic       sub_adv, sub_clr, step_go, step_from_min, adj_zero, set_cf, clr_adj;
    logic       wr_ctl1, wr_ctl2, wr_cnt;

    assign run     = start_q && en_q && !prst_q;
    assign wr_ctl1 = bus_wr && (bus_addr == OFS_CTL1);
    assign wr_ctl2 = bus_wr && (bus_addr == OFS_CTL2);
    assign wr_cnt  = bus_wr && !start_q;
    assign wrap    = sub_adv && sub_at_max;

    rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_subsec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sub_clr),
        .adv      (sub_adv),
        .cnt_byte (sub_byte),
        .at_max   (sub_at_max)
    );

    rtc_cal_step #(.FOUR_DIGIT_YEAR(FOUR_DIGIT_YEAR)) u_step (
        .cur      (cal_q),
        .from_min (step_from_min),
        .nxt      (step_nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Next state and per-state controls
    always_comb begin
        state_d       = state_q;
        sub_adv       = 1'b0;
        sub_clr       = prst_q;
        step_go       = 1'b0;
        step_from_min = 1'b0;
        adj_zero      = 1'b0;
        set_cf        = 1'b0;
        clr_adj       = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (adj_q)    state_d = ST_ADJ;
                else if (run) state_d = ST_RUN;
            end
            ST_RUN: begin
                sub_adv = tick && run && !adj_q;
                if (adj_q)     state_d = ST_ADJ;
                else if (!run) state_d = ST_STOP;
                else if (wrap) state_d = ST_CARRY;
            end
            ST_CARRY: begin
                step_go = 1'b1;
                set_cf  = 1'b1;
                state_d = run ? ST_RUN : ST_STOP;
            end
            ST_ADJ: begin
                sub_clr       = 1'b1;
                clr_adj       = 1'b1;
                step_go       = (cal_q.sec >= 8'h30);
                step_from_min = 1'b1;
                adj_zero      = (cal_q.sec < 8'h30);
                state_d       = run ? ST_RUN : ST_STOP;
            end
        endcase
    end

    // Calendar fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q       <= '0;
            cal_q.day   <= 8'h01;
            cal_q.mon   <= 8'h01;
            cal_q.yr_hi <= RST_CENTURY;
        end else if (step_go) begin
            cal_q <= step_nxt;
        end else if (adj_zero) begin
            cal_q.sec <= 8'h00;
        end else if (wr_cnt) begin
            case (bus_addr)
                OFS_SEC:  cal_q.sec   <= bus_wdata;
                OFS_MIN:  cal_q.min   <= bus_wdata;
                OFS_HR:   cal_q.hr    <= bus_wdata;
                OFS_WDAY: cal_q.wday  <= bus_wdata;
                OFS_DAY:  cal_q.day   <= bus_wdata;
                OFS_MON:  cal_q.mon   <= bus_wdata;
                OFS_YRLO: cal_q.yr_lo <= bus_wdata;
                OFS_YRHI: if (FOUR_DIGIT_YEAR) cal_q.yr_hi <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf_q    <= 1'b0;
            cie_q   <= 1'b0;
            en_q    <= 1'b0;
            adj_q   <= 1'b0;
            prst_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            if (set_cf)                        cf_q <= 1'b1;
            else if (wr_ctl1 && !bus_wdata[7]) cf_q <= 1'b0;
            if (wr_ctl1) cie_q <= bus_wdata[4];
            if (wr_ctl2) begin
                en_q    <= bus_wdata[3];
                adj_q   <= bus_wdata[2];
                prst_q  <= bus_wdata[1];
                start_q <= bus_wdata[0];
            end else if (clr_adj) begin
                adj_q <= 1'b0;
            end
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            case (bus_addr)
                OFS_SUB:  bus_rdata = sub_byte;
                OFS_SEC:  bus_rdata = cal_q.sec;
                OFS_MIN:  bus_rdata = cal_q.min;
                OFS_HR:   bus_rdata = cal_q.hr;
                OFS_WDAY: bus_rdata = cal_q.wday;
                OFS_DAY:  bus_rdata = cal_q.day;
                OFS_MON:  bus_rdata = cal_q.mon;
                OFS_YRLO: bus_rdata = cal_q.yr_lo;
                OFS_YRHI: bus_rdata = FOUR_DIGIT_YEAR ? cal_q.yr_hi : 8'h00;
                OFS_CTL1: bus_rdata = {cf_q, 2'b00, cie_q, 4'b0000};
                OFS_CTL2: bus_rdata = {4'b0000, en_q, adj_q, prst_q, start_q};
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    assign carry_irq = cf_q && cie_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input rtc_state_e state_q,
    input cal_t       cal_q,
    input logic       cf_q,
    input logic       cie_q,
    input logic       adj_q,
    input logic       prst_q,
    input logic [7:0] sub_byte,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       carry_irq
);
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CARRY && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00));

    assert_wday_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CARRY && cal_q.wday == 8'h06 && cal_q.hr == 8'h23 &&
         cal_q.min == 8'h59 && cal_q.sec == 8'h59) |=> (cal_q.wday == 8'h00));

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !bus_wr) |=> $stable(cal_q));

    assert_prst_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prst_q |=> (sub_byte == 8'h00));

    assert_cf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CARRY) |=> cf_q);

    assert_cf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_q && !(bus_wr && bus_addr == OFS_CTL1 && !bus_wdata[7])) |=> cf_q);

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CARRY && cie_q && !(bus_wr && bus_addr == OFS_CTL1)) |=> carry_irq);

    assert_adj_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADJ && !bus_wr) |=> (!adj_q && sub_byte == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .cal_q     (cal_q),
    .cf_q      (cf_q),
    .cie_q     (cie_q),
    .adj_q     (adj_q),
    .prst_q    (prst_q),
    .sub_byte  (sub_byte),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .carry_irq (carry_irq)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    localparam int TPS = 4;
    localparam logic [7:0] C_EN = 8'h08, C_ADJ = 8'h04, C_PRST = 8'h02, C_START = 8'h01;

    // {load value, expected after one second}; fields yr_hi yr_lo mon day wday hr min sec
    localparam logic [127:0] VEC [14] = '{
        128'h2024_0510_0300_0005_2024_0510_0300_0006,
        128'h2099_1231_0623_5959_2100_0101_0000_0000,
        128'h2024_0228_0223_5959_2024_0229_0300_0000,
        128'h2023_0228_0123_5959_2023_0301_0200_0000,
        128'h2024_0229_0423_5959_2024_0301_0500_0000,
        128'h2024_0430_0023_5959_2024_0501_0100_0000,
        128'h2024_0131_0523_5959_2024_0201_0600_0000,
        128'h2024_0610_0312_3459_2024_0610_0312_3500,
        128'h2024_0610_0309_5959_2024_0610_0310_0000,
        128'h2019_1231_0223_5959_2020_0101_0300_0000,
        128'h2012_0228_0223_5959_2012_0229_0300_0000,
        128'h2018_0228_0323_5959_2018_0301_0400_0000,
        128'h2024_0930_0123_5959_2024_1001_0200_0000,
        128'h2024_1130_0623_5959_2024_1201_0000_0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       carry_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rtc_calendar #(.TICKS_PER_SEC(TPS), .FOUR_DIGIT_YEAR(1'b1)) u_rtc_calendar (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .carry_irq (carry_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic load_cal(input logic [63:0] c);
        for (int k = 0; k < 8; k++) wr(4'(k + 1), c[8*k +: 8]);
    endtask

    task automatic read_cal(output logic [63:0] c);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) begin
            rd(4'(k + 1), b);
            c[8*k +: 8] = b;
        end
    endtask

    task automatic one_second();
        wr(4'd15, C_EN | C_PRST);
        wr(4'd15, C_EN | C_START);
        idle(3);
        repeat (TPS) pulse_tick();
        idle(4);
        wr(4'd15, C_EN);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired before end of tests");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] cal, hold;
        logic [7:0]  b;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        read_cal(cal);      check("R1 calendar after reset", cal, 64'h2000_0101_0000_0000);
        rd(4'd0, b);        check("R1 sub-second after reset", 64'(b), 64'h0);
        rd(4'd14, b);       check("R1 control 1 after reset", 64'(b), 64'h0);
        rd(4'd15, b);       check("R1 control 2 after reset", 64'(b), 64'h0);
        check("R1 carry_irq after reset", 64'(carry_irq), 64'h0);
        // R10 unmapped offset and read strobe low
        rd(4'd10, b);       check("R10 unmapped offset reads 0", 64'(b), 64'h0);
        @(negedge clk); bus_addr = 4'd6; #1;
        check("R10 rdata idle without read strobe", 64'(bus_rdata), 64'h0);

        // Calendar table: R2 R3 R4 rollovers over one second each
        for (int i = 0; i < 14; i++) begin
            wr(4'd14, 8'h00);
            wr(4'd15, C_EN);
            load_cal(VEC[i][127:64]);
            one_second();
            read_cal(cal);
            check($sformatf("R2 R3 R4 calendar vector %0d", i), cal, VEC[i][63:0]);
        end

        // R7 flag set by last second and sticky; R8 interrupt gating
        rd(4'd14, b);       check("R7 carry flag set after a second", 64'(b), 64'h80);
        check("R8 irq low while enable clear", 64'(carry_irq), 64'h0);
        wr(4'd14, 8'h90);
        rd(4'd14, b);       check("R7 writing 1 keeps flag", 64'(b), 64'h90);
        check("R8 irq high with flag and enable", 64'(carry_irq), 64'h1);
        wr(4'd14, 8'h10);
        rd(4'd14, b);       check("R7 writing 0 clears flag", 64'(b), 64'h10);
        check("R8 irq low after flag clear", 64'(carry_irq), 64'h0);
        one_second();
        check("R8 irq raised by next carry", 64'(carry_irq), 64'h1);
        wr(4'd14, 8'h00);

        // R5 hold while stopped and while enable clear; writes blocked while start set
        hold = 64'h2024_0610_0312_3456;
        wr(4'd15, C_EN);
        load_cal(hold);
        repeat (6) pulse_tick();
        read_cal(cal);      check("R5 hold with start clear", cal, hold);
        rd(4'd0, b);        check("R5 sub-second holds with start clear", 64'(b), 64'h0);
        wr(4'd15, C_START);
        repeat (6) pulse_tick();
        rd(4'd0, b);        check("R5 sub-second holds with enable clear", 64'(b), 64'h0);
        wr(4'd1, 8'h42);
        rd(4'd1, b);        check("R5 write ignored while start set", 64'(b), 64'h56);
        wr(4'd15, C_EN);

        // R2 sub-second readback, R6 prescaler reset
        wr(4'd15, C_EN | C_START);
        idle(3);
        repeat (2) pulse_tick();
        rd(4'd0, b);        check("R2 sub-second count after two ticks", 64'(b), 64'h2);
        wr(4'd15, C_EN | C_START | C_PRST);
        idle(2);
        rd(4'd0, b);        check("R6 prescaler reset clears count", 64'(b), 64'h0);
        repeat (2) pulse_tick();
        rd(4'd0, b);        check("R6 count held while reset set", 64'(b), 64'h0);
        wr(4'd15, C_EN);

        // R9 adjust below 30 seconds, while running
        load_cal(64'h2024_0610_0312_3429);
        wr(4'd15, C_EN | C_START);
        idle(3);
        repeat (2) pulse_tick();
        wr(4'd15, C_EN | C_START | C_ADJ);
        idle(4);
        wr(4'd15, C_EN);
        read_cal(cal);      check("R9 adjust below 30 clears seconds", cal, 64'h2024_0610_0312_3400);
        rd(4'd0, b);        check("R9 adjust clears sub-second", 64'(b), 64'h0);
        rd(4'd15, b);       check("R9 adjust request self-clears", 64'(b), 64'h08);

        // R9 adjust at 45 seconds, stopped, full cascade into new year
        load_cal(64'h2024_1231_0223_5945);
        wr(4'd15, C_EN | C_ADJ);
        idle(4);
        read_cal(cal);      check("R9 adjust rounds up through year", cal, 64'h2025_0101_0300_0000);
        rd(4'd15, b);       check("R9 request clear after stopped adjust", 64'(b), 64'h08);

        summary();
        $finish;
    end
endmodule